// File: doc/BRIEF.md
# Vector element step sequencer

This block walks a vector operation over its elements. Software hands it an element count, a per-element sub-element count and starting element positions for the source side and the destination side. It then emits one source/destination index pair per clock until the operation completes. Each side keeps an element counter and a sub-element counter. A per-side inversion bit chooses which of the two counters moves fastest, so the source side and the destination side can be regrouped differently. A vertical-first mode splits the operation into bursts sized by a parallelism hint. Each burst waits for a pulse that marks the next instruction.

Out-of-range configuration is refused with a one-cycle trap. The whole iteration context acts like a sub-program-counter. When the surrounding core takes an exception, a save pulse freezes the sequence and copies its full context into a save register. A restore pulse reinstates that context and continues from the exact element where the sequence stopped, even if another operation ran in between.

Top module: `vstep_seq`

## Requirements
- R1: With an inversion bit clear, that side's sub-element counter moves fastest and wraps at the sub-element count, after which the element counter increments; the emitted index is element*subcount + sub-element.
- R2: With `cfg_pack` = 1, the source side is inverted: its element counter moves fastest, wraps from VL-1 to 0, and then the sub-element counter increments.
- R3: `cfg_unpack` = 1 inverts the destination side in the same way, independently of `cfg_pack`.
- R4: `done_o` is high together with the element where either side reaches element VL-1 and sub-element count-1. A start with VL = 0, or with a starting step of at least VL, gives `done_o` alone, one cycle after the start, with no element.
- R5: A start with VL > 64, MVL > 64, srcstep >= 64 or dststep >= 64 gives `trap_o` alone for one cycle and issues no element and no done. VL = 64 with a starting step of 63 is legal.
- R6: A start is captured on a rising edge. The first element is on the outputs after the next edge, and further elements follow one per cycle.
- R7: With `cfg_vf` = 1, each burst issues max(`cfg_hint`,1) elements and then waits for a `next_insn` pulse. A hint of 0 means one element per burst.
- R8: `exc_save` stops iteration at the edge where it is sampled: no element is issued on that edge or after it. It copies the steps, sub-steps, configuration and a live flag into the save register.
- R9: `exc_restore` reloads the saved context and resumes at the saved source and destination positions. This holds even after another operation has run in between.
- R10: `cfg_subc` encodes the sub-element count as code+1 (0..3 gives 1..4).
- R11: While reset is high, and on the cycle after it, `valid_o`, `done_o` and `trap_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| start | input | 1 | load the configuration and begin |
| cfg_vl | input | 7 | element count VL |
| cfg_mvl | input | 7 | maximum element count (range checked only) |
| cfg_subc | input | 2 | sub-element count code |
| cfg_srcstep | input | 7 | starting source element |
| cfg_dststep | input | 7 | starting destination element |
| cfg_pack | input | 1 | invert source loop nesting |
| cfg_unpack | input | 1 | invert destination loop nesting |
| cfg_vf | input | 1 | vertical-first burst mode |
| cfg_hint | input | 3 | parallelism hint, burst size |
| next_insn | input | 1 | release the next burst |
| exc_save | input | 1 | exception entry: halt and save context |
| exc_restore | input | 1 | exception return: reload context and resume |
| valid_o | output | 1 | an index pair is present |
| src_idx_o | output | 8 | source element index |
| dst_idx_o | output | 8 | destination element index |
| done_o | output | 1 | end of the operation |
| trap_o | output | 1 | illegal configuration |

## Verification
The hardest state to reach from the ports is a save taken in the middle of a mixed-nesting sequence, followed by an unrelated operation, followed by a restore. The bench times the save pulse so that exactly five elements of a packed sequence have come out. It then runs a second, normal job that overwrites every counter. After the restore, the scoreboard expects the remaining seven elements of the first sequence, in its inverted order, ending with done.

// File: rtl/vstep_pkg.sv
package vstep_pkg;
  localparam int DEF_VL_MAX  = 64;
  localparam int DEF_SUB_MAX = 4;
  localparam int DEF_HINT_W  = 3;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_RUN   = 2'd1,
    SQ_PAUSE = 2'd2
  } sq_state_e;
endpackage

// File: rtl/vstep_cfg_check.sv
module vstep_cfg_check #(
  parameter int VL_MAX = 64,
  parameter int STEP_W = 7
) (
  input  logic [STEP_W-1:0] vl,
  input  logic [STEP_W-1:0] mvl,
  input  logic [STEP_W-1:0] srcstep,
  input  logic [STEP_W-1:0] dststep,
  output logic              illegal,
  output logic              empty
);
  localparam logic [STEP_W-1:0] LIMIT = STEP_W'(VL_MAX);

  always_comb begin
    illegal = (vl > LIMIT) || (mvl > LIMIT) ||
              (srcstep >= LIMIT) || (dststep >= LIMIT);
    empty   = (vl == '0) || (srcstep >= vl) || (dststep >= vl);
  end
endmodule

// File: rtl/vstep_side.sv
module vstep_side #(
  parameter int STEP_W = 7,
  parameter int SUB_W  = 2,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              advance,
  input  logic              invert,
  input  logic [STEP_W-1:0] ld_step,
  input  logic [SUB_W-1:0]  ld_sub,
  input  logic [STEP_W-1:0] vl,
  input  logic [SUB_W-1:0]  subc,
  output logic [STEP_W-1:0] step,
  output logic [SUB_W-1:0]  sub,
  output logic [IDX_W-1:0]  idx,
  output logic              at_end
);
  logic [STEP_W-1:0] vl_top;
  logic              step_wrap;
  logic              sub_wrap;
  logic [IDX_W-1:0]  mul_a;
  logic [IDX_W-1:0]  mul_b;

  always_comb begin
    vl_top    = vl - 1'b1;
    step_wrap = (step == vl_top);
    sub_wrap  = (sub == subc);
    at_end    = step_wrap && sub_wrap;
    mul_a     = IDX_W'(step);
    mul_b     = IDX_W'(subc) + IDX_W'(1);
    idx       = mul_a * mul_b + IDX_W'(sub);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= '0;
      sub  <= '0;
    end else if (load) begin
      step <= ld_step;
      sub  <= ld_sub;
    end else if (advance) begin
      if (invert) begin
        if (step_wrap) begin
          step <= '0;
          sub  <= sub + 1'b1;
        end else begin
          step <= step + 1'b1;
        end
      end else begin
        if (sub_wrap) begin
          sub  <= '0;
          step <= step + 1'b1;
        end else begin
          sub <= sub + 1'b1;
        end
      end
    end
  end

  // R1: sub-element never beyond the count while iterating
  a_r1_sub_bound: assert property (@(posedge clk) disable iff (rst)
    advance |-> (sub <= subc));

  // R1: normal nesting, sub-element moves first
  a_r1_sub_fastest: assert property (@(posedge clk) disable iff (rst)
    (advance && !load && !invert && !sub_wrap) |=>
      (step == $past(step)) && (sub == $past(sub) + 1'b1));

  // R2/R3: inverted nesting, element moves first
  a_r2_step_fastest: assert property (@(posedge clk) disable iff (rst)
    (advance && !load && invert && !step_wrap) |=>
      (sub == $past(sub)) && (step == $past(step) + 1'b1));
endmodule

// File: rtl/vstep_savereg.sv
module vstep_savereg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         save,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (save) q <= d;
  end
endmodule

// File: rtl/vstep_seq.sv
module vstep_seq
  import vstep_pkg::*;
#(
  parameter int VL_MAX  = DEF_VL_MAX,
  parameter int SUB_MAX = DEF_SUB_MAX,
  parameter int HINT_W  = DEF_HINT_W
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start,
  input  logic [$clog2(VL_MAX+1)-1:0]       cfg_vl,
  input  logic [$clog2(VL_MAX+1)-1:0]       cfg_mvl,
  input  logic [$clog2(SUB_MAX)-1:0]        cfg_subc,
  input  logic [$clog2(VL_MAX+1)-1:0]       cfg_srcstep,
  input  logic [$clog2(VL_MAX+1)-1:0]       cfg_dststep,
  input  logic                              cfg_pack,
  input  logic                              cfg_unpack,
  input  logic                              cfg_vf,
  input  logic [HINT_W-1:0]                 cfg_hint,
  input  logic                              next_insn,
  input  logic                              exc_save,
  input  logic                              exc_restore,
  output logic                              valid_o,
  output logic [$clog2(VL_MAX*SUB_MAX)-1:0] src_idx_o,
  output logic [$clog2(VL_MAX*SUB_MAX)-1:0] dst_idx_o,
  output logic                              done_o,
  output logic                              trap_o
);
  localparam int STEP_W = $clog2(VL_MAX+1);
  localparam int SUB_W  = $clog2(SUB_MAX);
  localparam int IDX_W  = $clog2(VL_MAX*SUB_MAX);
  localparam int POS_W  = STEP_W + SUB_W;
  localparam int CFG_W  = STEP_W + SUB_W + 3 + HINT_W;
  localparam int CTX_W  = 1 + CFG_W + 2*POS_W;

  sq_state_e         state;
  logic [STEP_W-1:0] vl_q;
  logic [SUB_W-1:0]  subc_q;
  logic              pack_q, unpack_q, vf_q;
  logic [HINT_W-1:0] hint_q;
  logic [HINT_W-1:0] burst;
  logic [HINT_W-1:0] hint_eff;

  logic illegal, empty;
  logic save_go, restore_go, start_go, next_go, issue, last;

  // per-side arrays: index 0 = source, 1 = destination
  logic              side_inv  [2];
  logic [STEP_W-1:0] side_ldst [2];
  logic [SUB_W-1:0]  side_ldsb [2];
  logic [STEP_W-1:0] side_step [2];
  logic [SUB_W-1:0]  side_sub  [2];
  logic [IDX_W-1:0]  side_idx  [2];
  logic              side_end  [2];

  logic [CTX_W-1:0]  ctx_now, ctx_saved;
  logic              sv_live;
  logic [STEP_W-1:0] sv_vl;
  logic [SUB_W-1:0]  sv_subc;
  logic              sv_pack, sv_unpack, sv_vf;
  logic [HINT_W-1:0] sv_hint;
  logic [STEP_W-1:0] sv_sstep, sv_dstep;
  logic [SUB_W-1:0]  sv_ssub, sv_dsub;

  vstep_cfg_check #(.VL_MAX(VL_MAX), .STEP_W(STEP_W)) u_chk (
    .vl(cfg_vl), .mvl(cfg_mvl), .srcstep(cfg_srcstep), .dststep(cfg_dststep),
    .illegal(illegal), .empty(empty)
  );

  always_comb begin
    ctx_now = {(state != SQ_IDLE), vl_q, subc_q, pack_q, unpack_q, vf_q, hint_q,
               side_step[0], side_sub[0], side_step[1], side_sub[1]};
    {sv_live, sv_vl, sv_subc, sv_pack, sv_unpack, sv_vf, sv_hint,
     sv_sstep, sv_ssub, sv_dstep, sv_dsub} = ctx_saved;
  end

  vstep_savereg #(.W(CTX_W)) u_save (
    .clk(clk), .rst(rst), .save(exc_save), .d(ctx_now), .q(ctx_saved)
  );

  always_comb begin
    save_go    = exc_save;
    restore_go = exc_restore && !exc_save;
    start_go   = start && !exc_save && !exc_restore && !illegal && !empty;
    next_go    = next_insn && !start && !exc_save && !exc_restore && (state == SQ_PAUSE);
    issue      = (state == SQ_RUN) && !start && !exc_save && !exc_restore;
    hint_eff   = (hint_q == '0) ? HINT_W'(1) : hint_q;
    side_inv[0]  = pack_q;
    side_inv[1]  = unpack_q;
    side_ldst[0] = restore_go ? sv_sstep : cfg_srcstep;
    side_ldst[1] = restore_go ? sv_dstep : cfg_dststep;
    side_ldsb[0] = restore_go ? sv_ssub  : '0;
    side_ldsb[1] = restore_go ? sv_dsub  : '0;
    last         = side_end[0] || side_end[1];
  end

  for (genvar g = 0; g < 2; g++) begin : g_side
    vstep_side #(.STEP_W(STEP_W), .SUB_W(SUB_W), .IDX_W(IDX_W)) u_side (
      .clk(clk), .rst(rst),
      .load(restore_go || start_go), .advance(issue), .invert(side_inv[g]),
      .ld_step(side_ldst[g]), .ld_sub(side_ldsb[g]),
      .vl(vl_q), .subc(subc_q),
      .step(side_step[g]), .sub(side_sub[g]),
      .idx(side_idx[g]), .at_end(side_end[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      vl_q      <= '0;
      subc_q    <= '0;
      pack_q    <= 1'b0;
      unpack_q  <= 1'b0;
      vf_q      <= 1'b0;
      hint_q    <= '0;
      burst     <= '0;
      valid_o   <= 1'b0;
      done_o    <= 1'b0;
      trap_o    <= 1'b0;
      src_idx_o <= '0;
      dst_idx_o <= '0;
    end else begin
      valid_o <= 1'b0;
      done_o  <= 1'b0;
      trap_o  <= 1'b0;
      if (save_go) begin
        state <= SQ_IDLE;
      end else if (restore_go) begin
        vl_q     <= sv_vl;
        subc_q   <= sv_subc;
        pack_q   <= sv_pack;
        unpack_q <= sv_unpack;
        vf_q     <= sv_vf;
        hint_q   <= sv_hint;
        burst    <= '0;
        state    <= sv_live ? SQ_RUN : SQ_IDLE;
      end else if (start) begin
        if (illegal) begin
          trap_o <= 1'b1;
          state  <= SQ_IDLE;
        end else if (empty) begin
          done_o <= 1'b1;
          state  <= SQ_IDLE;
        end else begin
          vl_q     <= cfg_vl;
          subc_q   <= cfg_subc;
          pack_q   <= cfg_pack;
          unpack_q <= cfg_unpack;
          vf_q     <= cfg_vf;
          hint_q   <= cfg_hint;
          burst    <= '0;
          state    <= SQ_RUN;
        end
      end else if (next_go) begin
        burst <= '0;
        state <= SQ_RUN;
      end else if (issue) begin
        valid_o   <= 1'b1;
        src_idx_o <= side_idx[0];
        dst_idx_o <= side_idx[1];
        done_o    <= last;
        if (last) begin
          state <= SQ_IDLE;
        end else if (vf_q && (burst + 1'b1 == hint_eff)) begin
          burst <= '0;
          state <= SQ_PAUSE;
        end else begin
          burst <= burst + 1'b1;
        end
      end
    end
  end

  // R4: the final element leaves the sequencer idle
  a_r4_done_ends: assert property (@(posedge clk) disable iff (rst)
    (valid_o && done_o) |-> (state == SQ_IDLE));

  // R5: a trap comes alone
  a_r5_trap_alone: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> (!valid_o && !done_o));

  // R7: a burst never exceeds the effective hint
  a_r7_burst_bound: assert property (@(posedge clk) disable iff (rst)
    ((state == SQ_RUN) && vf_q) |-> (burst < hint_eff));

  // R8: save halts immediately
  a_r8_save_halts: assert property (@(posedge clk) disable iff (rst)
    exc_save |=> (!valid_o && (state == SQ_IDLE)));

  // R9: restore of a live context resumes iteration
  a_r9_restore_runs: assert property (@(posedge clk) disable iff (rst)
    (exc_restore && !exc_save && sv_live) |=> (state == SQ_RUN));

  // R11: reset quiets the outputs
  a_r11_reset_quiet: assert property (@(posedge clk)
    rst |=> (!valid_o && !done_o && !trap_o));
endmodule

// File: tb/sim_vstep_seq.sv
`timescale 1ns/1ps
module sim_vstep_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0, next_insn = 1'b0, exc_save = 1'b0, exc_restore = 1'b0;
  logic [6:0] cfg_vl = '0, cfg_mvl = '0, cfg_srcstep = '0, cfg_dststep = '0;
  logic [1:0] cfg_subc = '0;
  logic       cfg_pack = 1'b0, cfg_unpack = 1'b0, cfg_vf = 1'b0;
  logic [2:0] cfg_hint = '0;
  logic       valid_o, done_o, trap_o;
  logic [7:0] src_idx_o, dst_idx_o;

  always #4 clk = ~clk;

  vstep_seq u0 (
    .clk(clk), .rst(rst), .start(start), .cfg_vl(cfg_vl), .cfg_mvl(cfg_mvl),
    .cfg_subc(cfg_subc), .cfg_srcstep(cfg_srcstep), .cfg_dststep(cfg_dststep),
    .cfg_pack(cfg_pack), .cfg_unpack(cfg_unpack), .cfg_vf(cfg_vf), .cfg_hint(cfg_hint),
    .next_insn(next_insn), .exc_save(exc_save), .exc_restore(exc_restore),
    .valid_o(valid_o), .src_idx_o(src_idx_o), .dst_idx_o(dst_idx_o),
    .done_o(done_o), .trap_o(trap_o)
  );

  typedef struct {
    bit    v;
    int    s;
    int    d;
    bit    dn;
    bit    tr;
    string tag;
  } item_t;

  item_t exp_q[$];
  int    ex_s[$];
  int    ex_d[$];
  int    n_chk = 0, n_fail = 0, n_valid = 0;
  bit    finished = 1'b0;

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // monitor: pops one expected item per output event
  always @(negedge clk) begin
    if (!rst && (valid_o || done_o || trap_o)) begin
      if (valid_o) n_valid++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8", "unexpected output event", int'(valid_o), 0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        chk(valid_o == e.v, e.tag, "valid", int'(valid_o), int'(e.v));
        chk(done_o == e.dn, e.tag, "done", int'(done_o), int'(e.dn));
        chk(trap_o == e.tr, e.tag, "trap", int'(trap_o), int'(e.tr));
        if (e.v) begin
          chk(int'(src_idx_o) == e.s, e.tag, "src index", int'(src_idx_o), e.s);
          chk(int'(dst_idx_o) == e.d, e.tag, "dst index", int'(dst_idx_o), e.d);
        end
      end
    end
  end

  // index of flattened position p in the chosen nesting
  function automatic int pos_idx(int p, int vl, int subn, bit inv);
    if (!inv) return p;
    return (p % vl) * subn + (p / vl);
  endfunction

  task automatic model(int vl, int subn, int ss, int ds, bit pk, bit up);
    int tot, ps, pd, n;
    ex_s.delete();
    ex_d.delete();
    if (vl == 0 || ss >= vl || ds >= vl) return;
    tot = vl * subn;
    ps  = pk ? ss : ss * subn;
    pd  = up ? ds : ds * subn;
    n   = (tot - ps < tot - pd) ? tot - ps : tot - pd;
    for (int k = 0; k < n; k++) begin
      ex_s.push_back(pos_idx(ps + k, vl, subn, pk));
      ex_d.push_back(pos_idx(pd + k, vl, subn, up));
    end
  endtask

  task automatic push_range(int first, int lastk, string tag);
    for (int k = first; k <= lastk; k++) begin
      item_t e;
      e.v = 1'b1; e.s = ex_s[k]; e.d = ex_d[k];
      e.dn = (k == ex_s.size() - 1); e.tr = 1'b0; e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic push_flag(bit dn, bit tr, string tag);
    item_t e;
    e.v = 1'b0; e.s = 0; e.d = 0; e.dn = dn; e.tr = tr; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic set_cfg(int vl, int mvl, int subc, int ss, int ds, bit pk, bit up,
                         bit vf, int hint);
    cfg_vl = 7'(vl); cfg_mvl = 7'(mvl); cfg_subc = 2'(subc);
    cfg_srcstep = 7'(ss); cfg_dststep = 7'(ds);
    cfg_pack = pk; cfg_unpack = up; cfg_vf = vf; cfg_hint = 3'(hint);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // driver: computes expectation, pushes it, pulses start, waits
  task automatic run_job(int vl, int mvl, int subc, int ss, int ds, bit pk, bit up,
                         bit trap_exp, string tag, bit lat);
    if (trap_exp) begin
      push_flag(1'b0, 1'b1, tag);
    end else begin
      model(vl, subc + 1, ss, ds, pk, up);
      if (ex_s.size() == 0) push_flag(1'b1, 1'b0, tag);
      else push_range(0, ex_s.size() - 1, tag);
    end
    @(negedge clk);
    set_cfg(vl, mvl, subc, ss, ds, pk, up, 1'b0, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (lat) chk(valid_o == 1'b0, "R6", "valid right after start edge", int'(valid_o), 0);
    @(negedge clk);
    if (lat) chk(valid_o == 1'b1, "R6", "valid one edge later", int'(valid_o), 1);
    drain();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0 && done_o == 1'b0 && trap_o == 1'b0, "R11",
        "outputs during reset", int'({valid_o, done_o, trap_o}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(valid_o == 1'b0 && done_o == 1'b0 && trap_o == 1'b0, "R11",
        "outputs after reset", int'({valid_o, done_o, trap_o}), 0);

    run_job(2, 2, 0, 0, 0, 0, 0, 0, "R6", 1'b1);
    run_job(3, 3, 2, 0, 0, 0, 0, 0, "R1_R10", 1'b0);
    run_job(3, 8, 1, 0, 0, 1, 0, 0, "R2", 1'b0);
    run_job(4, 4, 2, 0, 0, 0, 1, 0, "R3", 1'b0);
    run_job(4, 4, 1, 1, 2, 1, 1, 0, "R4_mixed", 1'b0);
    run_job(5, 5, 1, 2, 0, 0, 1, 0, "R4_r2_r3", 1'b0);
    run_job(0, 0, 0, 0, 0, 0, 0, 0, "R4_empty", 1'b0);
    run_job(3, 3, 0, 5, 0, 0, 0, 0, "R4_past_end", 1'b0);
    run_job(65, 64, 0, 0, 0, 0, 0, 1, "R5_vl", 1'b0);
    run_job(4, 65, 0, 0, 0, 0, 0, 1, "R5_mvl", 1'b0);
    run_job(64, 64, 0, 64, 0, 0, 0, 1, "R5_src", 1'b0);
    run_job(64, 64, 0, 0, 127, 0, 0, 1, "R5_dst", 1'b0);
    run_job(64, 64, 0, 63, 63, 0, 0, 0, "R5_edge", 1'b0);
    run_job(64, 64, 3, 0, 0, 0, 0, 0, "R1_full", 1'b0);

    // R7: vertical-first bursts of 3
    model(4, 1, 0, 0, 0, 0);
    push_range(0, 3, "R7");
    base = n_valid;
    @(negedge clk);
    set_cfg(4, 4, 0, 0, 0, 0, 0, 1, 3);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (12) @(negedge clk);
    chk(n_valid - base == 3, "R7", "elements in first burst", n_valid - base, 3);
    next_insn = 1'b1;
    @(negedge clk);
    next_insn = 1'b0;
    drain();
    chk(n_valid - base == 4, "R7", "elements after next", n_valid - base, 4);

    // R7: hint of zero means one element per burst
    model(2, 2, 0, 0, 0, 0);
    push_range(0, 3, "R7_hint0");
    base = n_valid;
    @(negedge clk);
    set_cfg(2, 2, 1, 0, 0, 0, 0, 1, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
    chk(n_valid - base == 1, "R7", "hint0 burst size", n_valid - base, 1);
    for (int i = 0; i < 3; i++) begin
      next_insn = 1'b1;
      @(negedge clk);
      next_insn = 1'b0;
      repeat (4) @(negedge clk);
    end
    drain();
    chk(n_valid - base == 4, "R7", "hint0 total", n_valid - base, 4);

    // R8/R9: save mid-sequence, run another job, restore
    model(6, 2, 0, 0, 1, 0);
    push_range(0, 4, "R8");
    base = n_valid;
    @(negedge clk);
    set_cfg(6, 6, 1, 0, 0, 1, 0, 0, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    exc_save = 1'b1;
    @(negedge clk);
    exc_save = 1'b0;
    repeat (6) @(negedge clk);
    chk(n_valid - base == 5, "R8", "elements before save", n_valid - base, 5);
    chk(exp_q.size() == 0, "R8", "pending after save", exp_q.size(), 0);
    run_job(2, 2, 0, 0, 0, 0, 0, 0, "R9_between", 1'b0);
    model(6, 2, 0, 0, 1, 0);
    push_range(5, 11, "R9");
    base = n_valid;
    @(negedge clk);
    exc_restore = 1'b1;
    @(negedge clk);
    exc_restore = 1'b0;
    drain();
    chk(n_valid - base == 7, "R9", "elements after restore", n_valid - base, 7);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule